// File: doc/BRIEF.md
# Dual-Period Kick-Code Watchdog

This block is a watchdog timer on a small register port. Software first picks two period codes: one for the stretch after the watchdog is switched on, and one for every stretch after a service write. It then sets the enable bit. From then on a down-counter runs one step per clock. Software must write a fixed 8-bit service value into the service register before the counter runs out. If the counter runs out, the block raises a reset request and holds it until the next reset.

The port is plain. There is a write strobe with an address and write data, and a read path that returns the selected register in the same cycle from the address alone. A period code n selects a period of 2^(BASE_EXP+n) clock cycles. BASE_EXP is 16 by default. Code 0 is therefore the shortest period, and software can use it to force a quick reset. The enable bit stays set until reset, so a runaway program cannot switch the watchdog off.

The register offsets are: 0x0 control (bit 0 is enable), 0x4 period codes, 0x8 live count (read-only), 0xC service.

Top module: `rangesel_wdog`

## Requirements
- R1: After reset, control, period codes and live count all read 0, and reset_req is low.
- R2: The period-code register holds the running code in bits 3:0 and the start code in bits 7:4. Write-data bits above 7 are dropped. A new code takes effect at the next counter load.
- R3: Writing control (0x0) with bit 0 set while disabled sets enable and loads the counter with 2^(BASE_EXP+start code) - 1. Control then reads 1.
- R4: The enable bit is sticky. A control write with bit 0 clear leaves it at 1. A second enabling write does not reload the counter.
- R5: While enabled and not expired, the counter falls by one each cycle and reads live at 0x8. Writes to 0x8 have no effect.
- R6: reset_req rises exactly 2^(BASE_EXP+n) cycles after the edge that loaded period n, unless a service write intervenes. It then stays high and the counter holds at 0 until reset.
- R7: A write to 0xC whose data bits 7:0 equal 0x76, while enabled and not expired, reloads the counter with 2^(BASE_EXP+running code) - 1. Higher data bits are ignored.
- R8: Service writes with any other low byte are ignored. Service writes while disabled or after expiry are ignored too, and leave the count and reset_req unchanged.
- R9: A valid service write in the same cycle that the counter stands at 0 wins. The counter reloads and no reset request is raised.
- R10: Period code 0 gives the shortest period, 2^BASE_EXP cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset for both write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| reset_req | output | 1 | Expiry reset request, held until reset |

## Verification
Two events can fall in the same cycle: a valid service write, and the counter reaching zero. The bench provokes this by enabling with the shortest start period and counting clocks. It drives the service write so that it lands on exactly the edge where the live count reads 0. It then judges that the count reads the full running-period reload and that reset_req stays low. The same bench also lets a later period run out by one cycle to confirm that expiry still occurs on schedule.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 4;
  localparam int CODE_W = 4;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_RANGE = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_KICK  = 4'hC;
  localparam logic [7:0]        KICK_VAL  = 8'h76;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              expired,
  output logic              en_q,
  output code_t             init_code,
  output code_t             run_code,
  output logic              arm,
  output logic              kick_ok
);
  logic [2*CODE_W-1:0] range_q;

  // enabling write only counts while still disabled (sticky enable)
  assign arm     = we && (addr == OFS_CTRL) && wdata[0] && !en_q;
  assign kick_ok = we && (addr == OFS_KICK) && (wdata == KICK_VAL) && en_q && !expired;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      range_q <= '0;
    end else begin
      if (arm) en_q <= 1'b1;
      if (we && (addr == OFS_RANGE)) range_q <= wdata[2*CODE_W-1:0];
    end
  end

  assign init_code = range_q[2*CODE_W-1:CODE_W];
  assign run_code  = range_q[CODE_W-1:0];
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 16,
  parameter int CNT_W    = BASE_EXP + (1 << CODE_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             arm,
  input  logic             kick,
  input  code_t            init_code,
  input  code_t            run_code,
  output logic [CNT_W-1:0] count_q,
  output logic             expired_q
);
  function automatic logic [CNT_W-1:0] period_top(input code_t c);
    return (CNT_W'(1) << (BASE_EXP + int'(c))) - CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q   <= '0;
      expired_q <= 1'b0;
    end else if (arm) begin
      count_q <= period_top(init_code);
    end else if (kick) begin
      count_q <= period_top(run_code);   // service beats expiry at zero
    end else if (en && !expired_q) begin
      if (count_q != '0) count_q <= count_q - CNT_W'(1);
      else               expired_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_rmux.sv
module wdog_rmux
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  input  code_t             init_code,
  input  code_t             run_code,
  input  logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] count_ext;

  generate
    if (DATA_W > CNT_W) begin : g_pad
      assign count_ext = {{(DATA_W-CNT_W){1'b0}}, count};
    end else begin : g_trunc
      assign count_ext = count[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (addr)
      OFS_CTRL:  rdata = DATA_W'(en);
      OFS_RANGE: rdata = DATA_W'({init_code, run_code});
      OFS_COUNT: rdata = count_ext;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/rangesel_wdog.sv
module rangesel_wdog
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 16,
  parameter int DATA_W   = 32,
  localparam int CNT_W   = BASE_EXP + (1 << CODE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reset_req
);
  logic             en_q, arm, kick_ok, expired_q;
  code_t            init_code, run_code;
  logic [CNT_W-1:0] count_q;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:8];

  wdog_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata[7:0]), .expired(expired_q), .en_q(en_q),
    .init_code(init_code), .run_code(run_code), .arm(arm), .kick_ok(kick_ok)
  );

  wdog_count #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .en(en_q), .arm(arm), .kick(kick_ok),
    .init_code(init_code), .run_code(run_code),
    .count_q(count_q), .expired_q(expired_q)
  );

  wdog_rmux #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rmux (
    .addr(reg_addr), .en(en_q), .init_code(init_code), .run_code(run_code),
    .count(count_q), .rdata(reg_rdata)
  );

  assign reset_req = expired_q;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 16,
  parameter int CNT_W    = BASE_EXP + (1 << CODE_W)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             kick_ok,
  input code_t            run_code,
  input logic [CNT_W-1:0] count_q,
  input logic             reset_req
);
  a_r4_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);

  a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !kick_ok && !reset_req && count_q != '0) |=> count_q == $past(count_q) - CNT_W'(1));

  a_r6_expire_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !kick_ok && !reset_req && count_q == '0) |=> reset_req);

  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> (reset_req && count_q == '0));

  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    kick_ok |=> count_q == (CNT_W'(1) << (BASE_EXP + int'($past(run_code)))) - CNT_W'(1));

  a_r8_idle_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (count_q == '0 && !reset_req));

  a_r9_kick_wins: assert property (@(posedge clk) disable iff (!rst_n)
    kick_ok |=> !reset_req);
endmodule

bind rangesel_wdog wdog_checker #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .kick_ok(kick_ok),
  .run_code(run_code), .count_q(count_q), .reset_req(reset_req)
);

// File: tb/rangesel_wdog_tb.sv
module rangesel_wdog_tb;
  localparam int B = 4;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reset_req;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  event        mon_ev;

  always #10 clk = ~clk;

  rangesel_wdog #(.BASE_EXP(B)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reset_req(reset_req)
  );

  function automatic logic [31:0] top_of(input int code);
    return (32'd1 << (B + code)) - 32'd1;
  endfunction

  // monitor: pops expected read items and compares with the port
  initial begin
    forever begin
      @(mon_ev);
      if (exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (reg_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: rdata actual %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    reg_addr = a;
    #1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    ->mon_ev;
    #1;
  endtask

  task automatic chk_req(input logic e, input string t);
    n_chk++;
    if (reset_req !== e) begin
      n_fail++;
      $display("FAIL %s: reset_req actual %b expected %b", t, reset_req, e);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    rd(4'h0, 32'h0, "R1 ctrl");
    rd(4'h4, 32'h0, "R1 range");
    rd(4'h8, 32'h0, "R1 count");
    chk_req(1'b0, "R1 req");

    // R2 code register, upper bits dropped
    wr(4'h4, 32'h1A5);
    rd(4'h4, 32'hA5, "R2 readback");
    // R5 count register is read-only
    wr(4'h8, 32'h5);
    rd(4'h8, 32'h0, "R5 count write ignored");
    // R8 service while disabled ignored
    wr(4'hC, 32'h76);
    idle(40);
    rd(4'h8, 32'h0, "R8 kick disabled count");
    rd(4'h0, 32'h0, "R8 ctrl still off");
    chk_req(1'b0, "R8 no req disabled");

    // run: start code 1, running code 2
    do_reset();
    wr(4'h4, 32'h12);
    wr(4'h0, 32'h1);
    rd(4'h8, top_of(1), "R3 start load");
    rd(4'h0, 32'h1, "R3 ctrl set");
    idle(5);
    rd(4'h8, top_of(1) - 5, "R5 decrement");
    wr(4'h0, 32'h0);
    rd(4'h0, 32'h1, "R4 clear ignored");
    rd(4'h8, top_of(1) - 6, "R4 count unaffected");
    wr(4'h0, 32'h1);
    rd(4'h8, top_of(1) - 7, "R4 no reload");
    wr(4'hC, 32'h75);
    rd(4'h8, top_of(1) - 8, "R8 wrong code");
    wr(4'hC, 32'h176);
    rd(4'h8, top_of(2), "R7 kick reload");
    idle(63);
    chk_req(1'b0, "R6 not yet");
    rd(4'h8, 32'h0, "R6 count at zero");
    idle(1);
    chk_req(1'b1, "R6 expiry");
    wr(4'hC, 32'h76);
    chk_req(1'b1, "R8 kick after expiry");
    rd(4'h8, 32'h0, "R6 count held");
    idle(3);
    chk_req(1'b1, "R6 req held");

    // R9 / R10: start code 0, running code 3
    do_reset();
    wr(4'h4, 32'h03);
    wr(4'h0, 32'h1);
    rd(4'h8, top_of(0), "R10 shortest load");
    idle(15);
    rd(4'h8, 32'h0, "R9 at zero");
    wr(4'hC, 32'h76);
    rd(4'h8, top_of(3), "R9 kick wins reload");
    chk_req(1'b0, "R9 no expiry");
    wr(4'h4, 32'h00);
    wr(4'hC, 32'h76);
    rd(4'h8, top_of(0), "R2 new code on next load");
    idle(15);
    chk_req(1'b0, "R10 before");
    idle(1);
    chk_req(1'b1, "R10 shortest expiry");

    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule